// File: doc/BRIEF.md
# Stop-Mode Power Sequencer with Pin-State Hold

This block decides when a microcontroller-style system leaves run mode for one of two stop modes and how it comes back. In the deep mode the core is unpowered (only RAM stays alive), the regulator rests in standby, and the pad values are frozen in a bank of hold latches. In the shallow mode the clocks stop but every register keeps its contents, so the pads need no latching. The sequencer runs on its own always-on clock. It drives the core power enable, the core clock enable, the regulator standby line, the pad hold and a core reset request.

Wake-up depends on the mode. The deep mode accepts only the reset pin, the IRQ pin (always active low while deep) and the real-time-interrupt tick. It returns through a power-on-style core reset and sets a recovery flag. The shallow mode also accepts the keyboard-interrupt pins and resumes without a reset, unless the reset pin caused the wake. Software clears the recovery flag and releases the pad hold with a single acknowledge write.

Top module: `pwr_stop_seq`

## Requirements
- R1: After `rst_n` is released, the block is in run mode: `core_pwr_en`=1, `clk_en`=1, `reg_standby`=0, `core_rst_req`=0, `pin_hold`=0, `recov_flag`=0, and `pin_out` equals `port_out`.
- R2: A `stop_req` with `stop_deep`=1 in run mode, with no deep wake source active, enters deep stop at that clock edge. The outputs become `core_pwr_en`=0, `clk_en`=0, `reg_standby`=1 and `pin_hold`=1. `pin_out` keeps the value it had at that edge, whatever `port_out` does afterwards.
- R3: A `stop_req` with `stop_deep`=0 in run mode, with no shallow wake source active, enters shallow stop. The outputs become `core_pwr_en`=1, `clk_en`=0 and `reg_standby`=1. `pin_out` keeps following `port_out`.
- R4: The deep stop wakes only on `reset_pin_n` low, on `irq_pin` low (whatever `irq_pol` is), or on `rti_tick` high while `rti_rate` is nonzero. `kbi_pins` and an `irq_pin` high have no effect.
- R5: The shallow stop wakes on `reset_pin_n` low, on `irq_pin` equal to `irq_pol`, on any `kbi_pins` bit high, or on an enabled `rti_tick`. A wake from any of these except the reset pin returns straight to run mode with no core reset. A wake from the reset pin goes through the core reset sequence and leaves `recov_flag` at 0.
- R6: When `rti_rate` is 3'b000, `rti_tick` wakes neither stop mode.
- R7: A wake from deep stop asserts `core_rst_req` for RST_CYCLES (default 4) clock cycles. During this time `core_pwr_en`=1, `clk_en`=1 and `reg_standby`=0. `recov_flag` goes to 1 at the start of the sequence, and `pin_hold` stays 1 throughout.
- R8: In run mode, `ack_wr`=1 with `ack_data`=1 clears `recov_flag` and `pin_hold` at the same edge, after which `pin_out` follows `port_out`. An acknowledge write with `ack_data`=0, or one made in any state other than run mode, changes nothing.
- R9: Each wake input passes through a two-flop synchronizer. A wake input that changes between edges changes the mode outputs after the third rising edge that follows.
- R10: A stop request is ignored, and the block stays in run mode, while a synchronized wake source valid for the requested mode is active. A source that is not valid for that mode does not block the request.
- R11: `stop_req` has no effect outside run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low power-on reset of the sequencer |
| stop_req | input | 1 | Stop request from the core, synchronous |
| stop_deep | input | 1 | Mode select for the request: 1 deep, 0 shallow |
| reset_pin_n | input | 1 | External reset pin, active low, asynchronous |
| irq_pin | input | 1 | External interrupt pin, asynchronous |
| irq_pol | input | 1 | Configured IRQ active level for shallow stop (1 high) |
| kbi_pins | input | KBI_W | Keyboard-interrupt pins, active high, asynchronous |
| rti_tick | input | 1 | Real-time-interrupt event from the slow oscillator |
| rti_rate | input | RTI_SEL_W | Real-time-interrupt rate select; zero disables it |
| ack_wr | input | 1 | Write strobe of the acknowledge register |
| ack_data | input | 1 | Data written to the acknowledge bit |
| port_out | input | PIN_W | Pad values driven by port registers and peripherals |
| pin_out | output | PIN_W | Values actually driven onto the pads |
| core_pwr_en | output | 1 | Core power domain enable |
| clk_en | output | 1 | Core clock and oscillator enable |
| reg_standby | output | 1 | Regulator and ADC standby |
| pin_hold | output | 1 | Pad hold latches closed |
| recov_flag | output | 1 | Set after a deep-stop wake until acknowledged |
| core_rst_req | output | 1 | Power-on-style reset request to the core |

## Verification
The hardest case to reach is the window after a deep wake, where the core is back out of reset but the pads still show values that `port_out` has since overwritten. The stimulus gets there by changing `port_out` while the block sits in deep stop. It waits out the reset sequence, sends an acknowledge write with data 0 and only then the real one, and compares `pin_out` against a behavioural model at every cycle. Further sequences set a wake source that belongs to only one mode before a stop request, to show that only the sources valid for the requested mode block it. Another holds `irq_pol` high with `irq_pin` idle-high during deep stop, to show that the configured polarity is overridden.

// File: rtl/pwr_stop_pkg.sv
package pwr_stop_pkg;

   typedef enum logic [1:0] {
      PS_RUN     = 2'd0,
      PS_SHALLOW = 2'd1,
      PS_DEEP    = 2'd2,
      PS_WAKERST = 2'd3
   } pss_state_e;

   typedef struct packed {
      logic core_pwr_en;
      logic clk_en;
      logic reg_standby;
      logic core_rst_req;
   } pss_ctl_t;

   function automatic pss_ctl_t pss_decode(input pss_state_e st);
      pss_ctl_t c;
      case (st)
         PS_SHALLOW: c = '{core_pwr_en: 1'b1, clk_en: 1'b0, reg_standby: 1'b1, core_rst_req: 1'b0};
         PS_DEEP:    c = '{core_pwr_en: 1'b0, clk_en: 1'b0, reg_standby: 1'b1, core_rst_req: 1'b0};
         PS_WAKERST: c = '{core_pwr_en: 1'b1, clk_en: 1'b1, reg_standby: 1'b0, core_rst_req: 1'b1};
         default:    c = '{core_pwr_en: 1'b1, clk_en: 1'b1, reg_standby: 1'b0, core_rst_req: 1'b0};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pss_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{{W{RST_VAL}}}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d};
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pss_wake_unit.sv
module pss_wake_unit #(
   parameter int KBI_W     = 4,
   parameter int RTI_SEL_W = 3,
   parameter int STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reset_pin_n,
   input  logic                 irq_pin,
   input  logic                 irq_pol,
   input  logic [KBI_W-1:0]     kbi_pins,
   input  logic                 rti_tick,
   input  logic [RTI_SEL_W-1:0] rti_rate,
   output logic                 wake_deep,
   output logic                 wake_shallow,
   output logic                 wake_hard
);

   logic             rstn_s;
   logic             irq_s;
   logic             rti_s;
   logic [KBI_W-1:0] kbi_s;
   logic             rti_hit;

   pss_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) i_sync_rst (
      .clk(clk), .rst_n(rst_n), .d(reset_pin_n), .q(rstn_s));

   pss_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) i_sync_irq (
      .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(irq_s));

   pss_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) i_sync_rti (
      .clk(clk), .rst_n(rst_n), .d(rti_tick), .q(rti_s));

   generate
      for (genvar k = 0; k < KBI_W; k++) begin : g_kbi
         pss_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) i_sync_kbi (
            .clk(clk), .rst_n(rst_n), .d(kbi_pins[k]), .q(kbi_s[k]));
      end
   endgenerate

   assign rti_hit      = rti_s & (|rti_rate);
   assign wake_hard    = ~rstn_s;
   // deep stop: IRQ is forced active low, keyboard pins are not sources
   assign wake_deep    = wake_hard | ~irq_s | rti_hit;
   assign wake_shallow = wake_hard | (irq_s == irq_pol) | (|kbi_s) | rti_hit;

endmodule

// File: rtl/pss_pin_hold.sv
module pss_pin_hold #(
   parameter int PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             release_i,
   input  logic [PIN_W-1:0] port_out,
   output logic [PIN_W-1:0] pin_out,
   output logic             pin_hold
);

   logic [PIN_W-1:0] held_q;
   logic             hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         hold_q <= 1'b0;
      end else if (capture) begin
         held_q <= pin_out;
         hold_q <= 1'b1;
      end else if (release_i) begin
         hold_q <= 1'b0;
      end
   end

   assign pin_out  = hold_q ? held_q : port_out;
   assign pin_hold = hold_q;

endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
   import pwr_stop_pkg::*;
#(
   parameter int RST_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       stop_deep,
   input  logic       wake_deep,
   input  logic       wake_shallow,
   input  logic       wake_hard,
   input  logic       ack_wr,
   input  logic       ack_data,
   output pss_state_e state,
   output logic       capture,
   output logic       release_o,
   output logic       recov_flag
);

   localparam int CNT_W = $clog2(RST_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

   pss_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             recov_q, recov_d;
   logic             in_run;

   assign in_run    = (st_q == PS_RUN);
   assign capture   = in_run & stop_req & stop_deep & ~wake_deep;
   assign release_o = in_run & ack_wr & ack_data;

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      recov_d = recov_q;
      case (st_q)
         PS_RUN: begin
            if (release_o) recov_d = 1'b0;
            if (capture) begin
               st_d = PS_DEEP;
            end else if (stop_req && !stop_deep && !wake_shallow) begin
               st_d = PS_SHALLOW;
            end
         end
         PS_SHALLOW: begin
            if (wake_hard) begin
               st_d  = PS_WAKERST;
               cnt_d = CNT_LOAD;
            end else if (wake_shallow) begin
               st_d = PS_RUN;
            end
         end
         PS_DEEP: begin
            if (wake_deep) begin
               st_d    = PS_WAKERST;
               cnt_d   = CNT_LOAD;
               recov_d = 1'b1;
            end
         end
         default: begin
            if (cnt_q == '0) st_d = PS_RUN;
            else             cnt_d = cnt_q - 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_RUN;
         cnt_q   <= '0;
         recov_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         recov_q <= recov_d;
      end
   end

   assign state      = st_q;
   assign recov_flag = recov_q;

endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq
   import pwr_stop_pkg::*;
#(
   parameter int PIN_W      = 8,
   parameter int KBI_W      = 4,
   parameter int RTI_SEL_W  = 3,
   parameter int RST_CYCLES = 4,
   parameter int SYNC_STG   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stop_req,
   input  logic                 stop_deep,
   input  logic                 reset_pin_n,
   input  logic                 irq_pin,
   input  logic                 irq_pol,
   input  logic [KBI_W-1:0]     kbi_pins,
   input  logic                 rti_tick,
   input  logic [RTI_SEL_W-1:0] rti_rate,
   input  logic                 ack_wr,
   input  logic                 ack_data,
   input  logic [PIN_W-1:0]     port_out,
   output logic [PIN_W-1:0]     pin_out,
   output logic                 core_pwr_en,
   output logic                 clk_en,
   output logic                 reg_standby,
   output logic                 pin_hold,
   output logic                 recov_flag,
   output logic                 core_rst_req
);

   generate
      if (PIN_W < 1)      begin : g_bad_pin $error("pwr_stop_seq: PIN_W must be >= 1"); end
      if (KBI_W < 1)      begin : g_bad_kbi $error("pwr_stop_seq: KBI_W must be >= 1"); end
      if (RTI_SEL_W < 1)  begin : g_bad_rti $error("pwr_stop_seq: RTI_SEL_W must be >= 1"); end
      if (RST_CYCLES < 1) begin : g_bad_rst $error("pwr_stop_seq: RST_CYCLES must be >= 1"); end
   endgenerate

   logic       wake_deep, wake_shallow, wake_hard;
   logic       capture, release_w;
   pss_state_e state;
   pss_ctl_t   ctl;

   pss_wake_unit #(.KBI_W(KBI_W), .RTI_SEL_W(RTI_SEL_W), .STAGES(SYNC_STG)) i_wake (
      .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n), .irq_pin(irq_pin),
      .irq_pol(irq_pol), .kbi_pins(kbi_pins), .rti_tick(rti_tick), .rti_rate(rti_rate),
      .wake_deep(wake_deep), .wake_shallow(wake_shallow), .wake_hard(wake_hard));

   pss_fsm #(.RST_CYCLES(RST_CYCLES)) i_fsm (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_deep(stop_deep),
      .wake_deep(wake_deep), .wake_shallow(wake_shallow), .wake_hard(wake_hard),
      .ack_wr(ack_wr), .ack_data(ack_data), .state(state), .capture(capture),
      .release_o(release_w), .recov_flag(recov_flag));

   pss_pin_hold #(.PIN_W(PIN_W)) i_hold (
      .clk(clk), .rst_n(rst_n), .capture(capture), .release_i(release_w),
      .port_out(port_out), .pin_out(pin_out), .pin_hold(pin_hold));

   assign ctl          = pss_decode(state);
   assign core_pwr_en  = ctl.core_pwr_en;
   assign clk_en       = ctl.clk_en;
   assign reg_standby  = ctl.reg_standby;
   assign core_rst_req = ctl.core_rst_req;

endmodule

// File: rtl/pwr_stop_seq_chk.sv
module pwr_stop_seq_chk #(
   parameter int PIN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PIN_W-1:0] pin_out,
   input logic             core_pwr_en,
   input logic             clk_en,
   input logic             reg_standby,
   input logic             pin_hold,
   input logic             recov_flag,
   input logic             core_rst_req
);

   // R2
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_hold) |-> (!core_pwr_en && !clk_en && reg_standby));

   // R2
   held_pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_hold && $past(pin_hold)) |-> $stable(pin_out));

   // R2
   unpowered_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_pwr_en |-> pin_hold);

   // R3
   shallow_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pwr_en && !clk_en) |-> (reg_standby && !core_rst_req));

   // R7
   reset_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_req |-> (core_pwr_en && clk_en && !reg_standby));

   // R7
   flag_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recov_flag |-> pin_hold);

   // R8
   joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(recov_flag) |-> $fell(pin_hold));

endmodule

bind pwr_stop_seq pwr_stop_seq_chk #(.PIN_W(PIN_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .core_pwr_en(core_pwr_en),
   .clk_en(clk_en), .reg_standby(reg_standby), .pin_hold(pin_hold),
   .recov_flag(recov_flag), .core_rst_req(core_rst_req));

// File: tb/test_pwr_stop_seq.sv
`timescale 1ns/1ps
module test_pwr_stop_seq;

   localparam int PIN_W = 8;
   localparam int KBI_W = 4;
   localparam int RSTC  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 0, stop_deep = 0, reset_pin_n = 1, irq_pin = 1, irq_pol = 0;
   logic [KBI_W-1:0] kbi_pins = '0;
   logic rti_tick = 0;
   logic [2:0] rti_rate = 3'b001;
   logic ack_wr = 0, ack_data = 0;
   logic [PIN_W-1:0] port_out = 8'hA5;
   logic [PIN_W-1:0] pin_out;
   logic core_pwr_en, clk_en, reg_standby, pin_hold, recov_flag, core_rst_req;

   int checks = 0, failures = 0;
   bit done = 0;
   int wd_cnt = 0;

   always #4 clk = ~clk;   // 125 MHz

   pwr_stop_seq #(.PIN_W(PIN_W), .KBI_W(KBI_W), .RTI_SEL_W(3), .RST_CYCLES(RSTC), .SYNC_STG(2))
   i_pwr_stop_seq (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_deep(stop_deep),
      .reset_pin_n(reset_pin_n), .irq_pin(irq_pin), .irq_pol(irq_pol), .kbi_pins(kbi_pins),
      .rti_tick(rti_tick), .rti_rate(rti_rate), .ack_wr(ack_wr), .ack_data(ack_data),
      .port_out(port_out), .pin_out(pin_out), .core_pwr_en(core_pwr_en), .clk_en(clk_en),
      .reg_standby(reg_standby), .pin_hold(pin_hold), .recov_flag(recov_flag),
      .core_rst_req(core_rst_req));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   // mode: 0 run, 1 shallow, 2 deep, 3 reset sequence
   int m_mode, m_cnt;
   bit m_recov, m_hold;
   logic [PIN_W-1:0] m_held, m_pin_now;
   bit q_rstn[$], q_irq[$], q_rti[$];
   int q_kbi[$];
   bit w_hard, w_irq, w_kbi, w_rti, w_deep, w_shal, w_rel;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_recov = 0; m_hold = 0; m_held = '0;
         q_rstn = '{1, 1}; q_irq = '{0, 0}; q_rti = '{0, 0}; q_kbi = '{0, 0};
      end else begin
         w_hard = !q_rstn[0];
         w_irq  = q_irq[0];
         w_kbi  = q_kbi[0] != 0;
         w_rti  = q_rti[0] && (rti_rate != 3'b000);
         w_deep = w_hard || !w_irq || w_rti;
         w_shal = w_hard || (w_irq == irq_pol) || w_kbi || w_rti;
         m_pin_now = m_hold ? m_held : port_out;
         case (m_mode)
            0: begin
               w_rel = ack_wr && ack_data;
               if (w_rel) m_recov = 0;
               if (stop_req && stop_deep && !w_deep) begin
                  m_mode = 2; m_held = m_pin_now; m_hold = 1;
               end else begin
                  if (w_rel) m_hold = 0;
                  if (stop_req && !stop_deep && !w_shal) m_mode = 1;
               end
            end
            1: if (w_hard) begin m_mode = 3; m_cnt = RSTC - 1; end
               else if (w_shal) m_mode = 0;
            2: if (w_deep) begin m_mode = 3; m_cnt = RSTC - 1; m_recov = 1; end
            default: if (m_cnt == 0) m_mode = 0; else m_cnt--;
         endcase
         q_rstn.push_back(reset_pin_n); void'(q_rstn.pop_front());
         q_irq.push_back(irq_pin);      void'(q_irq.pop_front());
         q_rti.push_back(rti_tick);     void'(q_rti.pop_front());
         q_kbi.push_back(int'(kbi_pins)); void'(q_kbi.pop_front());
      end
   end

   // compare on every clock, 2 ns after the edge (inputs move on the falling edge)
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         string t;
         case (m_mode)
            1: t = "R3"; 2: t = "R2"; 3: t = "R7"; default: t = "R1";
         endcase
         chk({t, " core_pwr_en"}, core_pwr_en, m_mode != 2);
         chk({t, " clk_en"}, clk_en, (m_mode == 0) || (m_mode == 3));
         chk({t, " reg_standby"}, reg_standby, (m_mode == 1) || (m_mode == 2));
         chk("R7 core_rst_req", core_rst_req, m_mode == 3);
         chk("R2 pin_hold", pin_hold, m_hold);
         chk("R2 pin_out", pin_out, m_hold ? m_held : port_out);
         chk("R8 recov_flag", recov_flag, m_recov);
      end
   end

   // watchdog
   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 20000 && !done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL R1 watchdog: actual=%0d expected=%0d", wd_cnt, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic req_stop(input bit deep);
      stop_deep = deep; stop_req = 1; cyc(1); stop_req = 0;
   endtask

   task automatic ack(input bit v);
      ack_data = v; ack_wr = 1; cyc(1); ack_wr = 0; ack_data = 0;
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(4);
      // R1 reset state
      chk("R1 core_pwr_en", core_pwr_en, 1);
      chk("R1 clk_en", clk_en, 1);
      chk("R1 pin_hold", pin_hold, 0);
      chk("R1 pin_out", pin_out, 8'hA5);

      // R2 deep entry, pins frozen
      req_stop(1);
      chk("R2 core_pwr_en", core_pwr_en, 0);
      port_out = 8'h3C;
      cyc(1);
      chk("R2 pin_out held", pin_out, 8'hA5);
      // R11 stop request in deep has no effect
      req_stop(0);
      chk("R11 still deep", core_pwr_en, 0);
      // R4 keyboard pins and a high IRQ with high polarity do not wake deep
      irq_pol = 1; kbi_pins = 4'b0011; cyc(6);
      chk("R4 kbi ignored", core_pwr_en, 0);
      kbi_pins = '0;
      // R8 acknowledge while deep is ignored
      ack(1); cyc(3);
      chk("R8 ack in deep", pin_hold, 1);
      // R4 IRQ low wakes deep regardless of polarity
      irq_pin = 0; cyc(3);
      chk("R7 reset asserted", core_rst_req, 1);
      chk("R7 flag set", recov_flag, 1);
      irq_pin = 1; irq_pol = 0;
      cyc(RSTC);
      chk("R7 reset done", core_rst_req, 0);
      chk("R7 pins still held", pin_out, 8'hA5);
      // R8 data 0 does nothing, data 1 releases
      ack(0);
      chk("R8 ack data0", pin_hold, 1);
      ack(1);
      chk("R8 released", pin_out, 8'h3C);
      chk("R8 flag cleared", recov_flag, 0);

      // R3 shallow entry, R9 sync latency, R5 kbi wake without reset
      req_stop(0);
      chk("R3 clk_en", clk_en, 0);
      port_out = 8'h5A; cyc(1);
      chk("R3 pins follow", pin_out, 8'h5A);
      kbi_pins = 4'b0100;
      cyc(1); chk("R9 edge1", clk_en, 0);
      cyc(1); chk("R9 edge2", clk_en, 0);
      cyc(1); chk("R9 edge3", clk_en, 1);
      chk("R5 no reset", core_rst_req, 0);
      // R10 kbi blocks a shallow request but not a deep one
      req_stop(0); cyc(1);
      chk("R10 shallow blocked", clk_en, 1);
      req_stop(1);
      chk("R10 deep allowed", core_pwr_en, 0);
      kbi_pins = '0;
      // R4 reset pin wakes deep
      reset_pin_n = 0; cyc(3);
      chk("R4 reset pin wake", core_rst_req, 1);
      reset_pin_n = 1; cyc(RSTC + 2);
      ack(1);
      chk("R8 release2", pin_hold, 0);

      // R6 disabled RTI cannot wake deep; enabled RTI can
      rti_rate = 3'b000; cyc(3);
      req_stop(1);
      rti_tick = 1; cyc(6); rti_tick = 0;
      chk("R6 rti disabled deep", core_pwr_en, 0);
      rti_rate = 3'b101; rti_tick = 1; cyc(3); rti_tick = 0;
      chk("R4 rti wake", core_rst_req, 1);
      cyc(RSTC + 2); ack(1);

      // R6 in shallow, then RTI wake, R5
      rti_rate = 3'b000; req_stop(0);
      rti_tick = 1; cyc(6); rti_tick = 0;
      chk("R6 rti disabled shallow", clk_en, 0);
      rti_rate = 3'b010; rti_tick = 1; cyc(3); rti_tick = 0;
      chk("R5 rti shallow wake", clk_en, 1);
      cyc(3);

      // R5 IRQ at configured level wakes shallow
      req_stop(0);
      irq_pin = 0; cyc(3);
      chk("R5 irq shallow wake", clk_en, 1);
      chk("R5 irq no reset", core_rst_req, 0);
      irq_pin = 1; cyc(3);

      // R5 reset pin in shallow: reset sequence, no flag
      req_stop(0);
      reset_pin_n = 0; cyc(3);
      chk("R5 reset from shallow", core_rst_req, 1);
      chk("R5 no flag", recov_flag, 0);
      reset_pin_n = 1;
      // R11 stop request during reset sequence ignored
      req_stop(1);
      chk("R11 in reset", core_pwr_en, 1);
      cyc(RSTC + 3);
      chk("R1 back to run", clk_en, 1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule